// File: doc/BRIEF.md
# Four-Phase Asynchronous Read Link

This block carries one read at a time between a requesting device and a memory responder that run on unrelated clocks. The two sides share a single data bus that carries first the address and then the returned word. Three control lines interlock them: a read request raised by the requester, an acknowledge line that either side may pull high (wired-OR), and a data-ready line raised by the responder. Each side watches the other side's lines only through a two-stage synchronizer in its own clock domain. Every step therefore waits for an edge it has actually seen from the other side, and no timing relation between the clocks is assumed.

The requester takes a one-cycle `start` pulse with an address and later returns the word with a one-cycle `done` pulse. The responder looks the word up on a plain combinational memory port. Before it raises data-ready, it waits a programmable number of its own cycles. The data bus is modelled as a drive value and a drive enable from each side, merged into one sampled value, so the two drivers can be seen at the ports.

Top module: `arl_link`

## Requirements
- R1: After reset, read_req, ack, data_rdy, req_oe, rsp_oe, busy and done are all 0.
- R2: A start pulse while idle makes read_req go high with the address on bus_val (bits AW-1:0, upper bits zero) in the next requester cycle. The address stays stable for as long as read_req is high.
- R3: The requester lowers read_req and stops driving the bus only after it has seen ack high. ack is therefore still high when read_req falls.
- R4: The responder lowers its acknowledge only after read_req is low. data_rdy is never high while read_req is high.
- R5: data_rdy is high only while the responder drives the bus. The word it drives is the memory word at the latched address, and that word appears on rd_data when done pulses.
- R6: The requester raises ack after it sees data_rdy. The responder lowers data_rdy only while ack is high. The transaction ends with all three lines low and a single done pulse.
- R7: With latency setting L (0 to 15), data_rdy rises exactly L+3 responder cycles after the responder lowers its acknowledge.
- R8: req_oe and rsp_oe are never high together.
- R9: A start pulse while busy is ignored. Exactly one done follows, and it carries the first address's word.
- R10: The responder raises its acknowledge only while read_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_clk | input | 1 | Requester clock |
| req_rst_n | input | 1 | Requester active-low reset |
| rsp_clk | input | 1 | Responder clock |
| rsp_rst_n | input | 1 | Responder active-low reset |
| start | input | 1 | Begin a read (requester domain, one cycle) |
| start_addr | input | AW | Address of the read |
| busy | output | 1 | Requester has a read in flight |
| done | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | DW | Word returned by the last read |
| lat | input | LW | Responder latency in its own cycles |
| mem_addr | output | AW | Latched address toward the memory |
| mem_rdata | input | DW | Memory word at mem_addr |
| read_req | output | 1 | Read request line |
| ack | output | 1 | Wired-OR acknowledge line |
| data_rdy | output | 1 | Data-ready line |
| req_oe | output | 1 | Requester drives the bus |
| rsp_oe | output | 1 | Responder drives the bus |
| bus_val | output | DW | Sampled value of the shared bus |

## Verification
The bench builds the block with AW=8, DW=16 and LW=4. This gives the full 0 to 15 latency range and lets the address differ from the 16-bit returned word in every bit. The requester runs at 4 ns and the responder at 7 ns. Because the clocks are unrelated, each synchronizer sees edges at a shifting phase. A fast requester waits on a slower responder, and the long latency setting holds the requester in its data wait for many cycles. Latency 0 covers the shortest path from dropped acknowledge to data-ready.

// File: rtl/arl_pkg.sv
package arl_pkg;

    typedef enum logic [2:0] {
        RQ_IDLE,
        RQ_ADDR,
        RQ_REL,
        RQ_WDAT,
        RQ_ACKH,
        RQ_ACKL
    } rq_state_e;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_GOT,
        RS_DROP,
        RS_WAIT,
        RS_DRIVE,
        RS_RELS
    } rs_state_e;

endpackage

// File: rtl/arl_sync.sv
module arl_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/arl_requester.sv
module arl_requester
    import arl_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          ack_line,
    input  logic          drdy_line,
    input  logic [DW-1:0] bus_in,
    output logic          read_req,
    output logic          ack_out,
    output logic          bus_oe,
    output logic [DW-1:0] bus_out,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        rq_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          rreq;
        logic          ack;
        logic          oe;
        logic          done;
    } rq_regs_t;

    rq_regs_t r_q, r_d;
    logic     ack_s, drdy_s;

    arl_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ack_line, drdy_line}),
        .q    ({ack_s, drdy_s})
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            RQ_IDLE: if (start) begin
                r_d.addr = start_addr;
                r_d.rreq = 1'b1;
                r_d.oe   = 1'b1;
                r_d.st   = RQ_ADDR;
            end
            RQ_ADDR: if (ack_s) begin
                r_d.rreq = 1'b0;
                r_d.oe   = 1'b0;
                r_d.st   = RQ_REL;
            end
            RQ_REL: if (!ack_s) begin
                r_d.st = RQ_WDAT;
            end
            RQ_WDAT: if (drdy_s) begin
                r_d.data = bus_in;
                r_d.ack  = 1'b1;
                r_d.st   = RQ_ACKH;
            end
            RQ_ACKH: if (!drdy_s) begin
                r_d.ack = 1'b0;
                r_d.st  = RQ_ACKL;
            end
            RQ_ACKL: if (!ack_s) begin
                r_d.done = 1'b1;
                r_d.st   = RQ_IDLE;
            end
            default: r_d.st = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= RQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign read_req = r_q.rreq;
    assign ack_out  = r_q.ack;
    assign bus_oe   = r_q.oe;
    assign bus_out  = DW'(r_q.addr);
    assign busy     = (r_q.st != RQ_IDLE);
    assign done     = r_q.done;
    assign rd_data  = r_q.data;
endmodule

// File: rtl/arl_responder.sv
module arl_responder
    import arl_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lat,
    input  logic          rreq_line,
    input  logic          ack_line,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          ack_out,
    output logic          drdy,
    output logic          bus_oe,
    output logic [DW-1:0] bus_out
);
    typedef struct packed {
        rs_state_e     st;
        logic [AW-1:0] addr;
        logic [LW-1:0] lat;
        logic [LW-1:0] cnt;
        logic [DW-1:0] data;
        logic          ack;
        logic          drdy;
        logic          oe;
    } rs_regs_t;

    rs_regs_t r_q, r_d;
    logic     rreq_s, ack_s;

    arl_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({rreq_line, ack_line}),
        .q    ({rreq_s, ack_s})
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RS_IDLE: if (rreq_s) begin
                r_d.addr = bus_in[AW-1:0];
                r_d.lat  = lat;
                r_d.ack  = 1'b1;
                r_d.st   = RS_GOT;
            end
            RS_GOT: if (!rreq_s) begin
                r_d.ack = 1'b0;
                r_d.st  = RS_DROP;
            end
            RS_DROP: if (!ack_s) begin
                if (r_q.lat == '0) begin
                    r_d.data = mem_rdata;
                    r_d.oe   = 1'b1;
                    r_d.drdy = 1'b1;
                    r_d.st   = RS_DRIVE;
                end else begin
                    r_d.cnt = r_q.lat;
                    r_d.st  = RS_WAIT;
                end
            end
            RS_WAIT: begin
                if (r_q.cnt == LW'(1)) begin
                    r_d.data = mem_rdata;
                    r_d.oe   = 1'b1;
                    r_d.drdy = 1'b1;
                    r_d.st   = RS_DRIVE;
                end else begin
                    r_d.cnt = r_q.cnt - LW'(1);
                end
            end
            RS_DRIVE: if (ack_s) begin
                r_d.oe   = 1'b0;
                r_d.drdy = 1'b0;
                r_d.st   = RS_RELS;
            end
            RS_RELS: if (!ack_s) begin
                r_d.st = RS_IDLE;
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr = r_q.addr;
    assign ack_out  = r_q.ack;
    assign drdy     = r_q.drdy;
    assign bus_oe   = r_q.oe;
    assign bus_out  = r_q.data;
endmodule

// File: rtl/arl_link.sv
module arl_link #(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          req_clk,
    input  logic          req_rst_n,
    input  logic          rsp_clk,
    input  logic          rsp_rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    input  logic [LW-1:0] lat,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          read_req,
    output logic          ack,
    output logic          data_rdy,
    output logic          req_oe,
    output logic          rsp_oe,
    output logic [DW-1:0] bus_val
);
    logic          req_ack, rsp_ack;
    logic [DW-1:0] req_do, rsp_do;

    assign ack     = req_ack | rsp_ack;
    assign bus_val = req_oe ? req_do : (rsp_oe ? rsp_do : '0);

    arl_requester #(.AW(AW), .DW(DW)) u_req (
        .clk       (req_clk),
        .rst_n     (req_rst_n),
        .start     (start),
        .start_addr(start_addr),
        .ack_line  (ack),
        .drdy_line (data_rdy),
        .bus_in    (bus_val),
        .read_req  (read_req),
        .ack_out   (req_ack),
        .bus_oe    (req_oe),
        .bus_out   (req_do),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data)
    );

    arl_responder #(.AW(AW), .DW(DW), .LW(LW)) u_rsp (
        .clk      (rsp_clk),
        .rst_n    (rsp_rst_n),
        .lat      (lat),
        .rreq_line(read_req),
        .ack_line (ack),
        .bus_in   (bus_val),
        .mem_addr (mem_addr),
        .mem_rdata(mem_rdata),
        .ack_out  (rsp_ack),
        .drdy     (data_rdy),
        .bus_oe   (rsp_oe),
        .bus_out  (rsp_do)
    );
endmodule

// File: rtl/arl_link_chk.sv
module arl_link_chk #(
    parameter int DW = 16,
    parameter int LW = 4
) (
    input logic          req_clk,
    input logic          req_rst_n,
    input logic          rsp_clk,
    input logic          rsp_rst_n,
    input logic [LW-1:0] lat,
    input logic          read_req,
    input logic          ack,
    input logic          rsp_ack,
    input logic          data_rdy,
    input logic          req_oe,
    input logic          rsp_oe,
    input logic [DW-1:0] bus_val
);
    logic [5:0] gap_q;

    always_ff @(posedge rsp_clk or negedge rsp_rst_n) begin
        if (!rsp_rst_n)        gap_q <= '0;
        else if (ack)          gap_q <= '0;
        else if (gap_q != '1)  gap_q <= gap_q + 6'd1;
    end

    AST_ADDR_STABLE: assert property (@(posedge req_clk) disable iff (!req_rst_n)
        (read_req && $past(read_req)) |-> $stable(bus_val)); // R2
    AST_REQ_FALL_AFTER_ACK: assert property (@(posedge req_clk) disable iff (!req_rst_n)
        $fell(read_req) |-> ack); // R3
    AST_ACK_FALL_AFTER_REQ: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
        $fell(rsp_ack) |-> !read_req); // R4
    AST_DRDY_DRIVES_BUS: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
        data_rdy |-> rsp_oe); // R5
    AST_DRDY_FALL_ON_ACK: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
        $fell(data_rdy) |-> ack); // R6
    AST_LATENCY_GAP: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
        $rose(data_rdy) |-> (int'(gap_q) >= int'(lat) + 2)); // R7
    AST_ONE_DRIVER: assert property (@(posedge req_clk) disable iff (!req_rst_n)
        !(req_oe && rsp_oe)); // R8
    AST_ACK_RISE_ON_REQ: assert property (@(posedge rsp_clk) disable iff (!rsp_rst_n)
        $rose(rsp_ack) |-> read_req); // R10
endmodule

bind arl_link arl_link_chk #(.DW(DW), .LW(LW)) u_chk (
    .req_clk  (req_clk),
    .req_rst_n(req_rst_n),
    .rsp_clk  (rsp_clk),
    .rsp_rst_n(rsp_rst_n),
    .lat      (lat),
    .read_req (read_req),
    .ack      (ack),
    .rsp_ack  (rsp_ack),
    .data_rdy (data_rdy),
    .req_oe   (req_oe),
    .rsp_oe   (rsp_oe),
    .bus_val  (bus_val)
);

// File: tb/arl_link_test.sv
module arl_link_test;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int NV = 8;

    // each entry: {address[11:4], latency[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {8'h00, 4'd0}, {8'hFF, 4'd15}, {8'h3C, 4'd1}, {8'hA5, 4'd7},
        {8'h81, 4'd2}, {8'h7E, 4'd0},  {8'h10, 4'd11}, {8'hC9, 4'd4}
    };

    logic          req_clk = 0, rsp_clk = 0;
    logic          req_rst_n = 0, rsp_rst_n = 0;
    logic          start = 0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] lat = '0;
    logic          busy, done, read_req, ack, data_rdy, req_oe, rsp_oe;
    logic [DW-1:0] rd_data, bus_val, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] ref_mem [1 << AW];

    int n_chk = 0, n_fail = 0;
    int viol = 0;
    int last_gap = -1;
    int gap_cnt = 0;
    bit counting = 0;
    logic prev_ack = 0, prev_drdy = 0;

    always #2 req_clk = ~req_clk;
    always #3.5 rsp_clk = ~rsp_clk;

    arl_link #(.AW(AW), .DW(DW), .LW(LW)) uut (
        .req_clk(req_clk), .req_rst_n(req_rst_n),
        .rsp_clk(rsp_clk), .rsp_rst_n(rsp_rst_n),
        .start(start), .start_addr(start_addr),
        .busy(busy), .done(done), .rd_data(rd_data),
        .lat(lat), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .read_req(read_req), .ack(ack), .data_rdy(data_rdy),
        .req_oe(req_oe), .rsp_oe(rsp_oe), .bus_val(bus_val)
    );

    function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
        return {a ^ 8'hC3, a + 8'h17};
    endfunction

    assign mem_rdata = ref_mem[mem_addr];

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // protocol monitors: R4 ordering, R8 single driver
    always @(negedge req_clk) if (req_rst_n && req_oe && rsp_oe) viol++;
    always @(negedge rsp_clk) begin
        if (rsp_rst_n && req_oe && rsp_oe) viol++;
        if (rsp_rst_n && data_rdy && read_req) viol++;
    end

    // R7: responder cycles from acknowledge fall to data-ready rise
    always @(negedge rsp_clk) begin
        if (prev_ack && !ack) begin
            counting = 1;
            gap_cnt  = 0;
        end else if (counting) begin
            gap_cnt++;
        end
        if (!prev_drdy && data_rdy && counting) begin
            last_gap = gap_cnt;
            counting = 0;
        end
        prev_ack  = ack;
        prev_drdy = data_rdy;
    end

    task automatic do_read(input logic [AW-1:0] a, input logic [LW-1:0] l);
        int v0;
        int t;
        v0 = viol;
        last_gap = -1;
        @(negedge req_clk);
        lat        = l;
        start      = 1;
        start_addr = a;
        @(negedge req_clk);
        start = 0;
        check("R2 read_req raised", DW'(read_req), DW'(1));
        check("R2 address on bus", bus_val, DW'(a));
        t = 0;
        while (!done && t < 2000) begin
            @(negedge req_clk);
            t++;
        end
        check("R6 done pulse", DW'(done), DW'(1));
        check("R5 returned word", rd_data, ref_word(a));
        check("R7 latency gap", DW'(last_gap), DW'(int'(l) + 3));
        check("R6 lines low at end", DW'({read_req, ack, data_rdy}), DW'(0));
        @(negedge req_clk);
        check("R6 done one cycle", DW'(done), DW'(0));
        check("R4 R8 protocol order", DW'(viol - v0), DW'(0));
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = ref_word(AW'(i));
        repeat (4) @(negedge rsp_clk);
        @(negedge req_clk);
        // R1 reset state
        check("R1 lines", DW'({read_req, ack, data_rdy}), DW'(0));
        check("R1 drivers", DW'({req_oe, rsp_oe}), DW'(0));
        check("R1 busy done", DW'({busy, done}), DW'(0));
        req_rst_n = 1;
        rsp_rst_n = 1;
        repeat (4) @(negedge req_clk);
        check("R1 idle after release", DW'({busy, read_req, ack, data_rdy}), DW'(0));

        for (int i = 0; i < NV; i++) do_read(VEC[i][11:4], VEC[i][3:0]);

        // R9: second start while busy is ignored
        begin
            int dones;
            int v0;
            v0 = viol;
            dones = 0;
            @(negedge req_clk);
            lat = 4'd15; start = 1; start_addr = 8'h5A;
            @(negedge req_clk);
            start = 0;
            repeat (6) @(negedge req_clk);
            check("R9 busy during read", DW'(busy), DW'(1));
            start = 1; start_addr = 8'h66;
            @(negedge req_clk);
            start = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge req_clk);
                if (done) begin
                    dones++;
                    check("R9 first address word", rd_data, ref_word(8'h5A));
                end
            end
            check("R9 single done", DW'(dones), DW'(1));
            check("R9 idle afterwards", DW'({busy, read_req, ack}), DW'(0));
            check("R8 no double drive", DW'(viol - v0), DW'(0));
        end

        // back-to-back reads at both latency extremes
        do_read(8'h01, 4'd15);
        do_read(8'hFE, 4'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule